// File: doc/BRIEF.md
# Downstream Resource Credit Tracker

This block sits beside a single thread's register-rename stage and decides how many instructions that stage may pass on in the current cycle. It keeps its own copy of the free-entry counts reported by three downstream structures: the reorder buffer, the issue queue and the load/store queue. It also keeps a count of instructions that have been renamed but not yet dispatched. From these it forms a signed credit for each structure and takes the smallest. It reports which structure is the limit, the number of instructions the stage may send, and whether the stage must stall entirely or send a clipped batch and block afterwards.

The stored free counts are updated only when their producer marks a new value as valid. Each credit is corrected for the instructions still in flight between rename and dispatch. The load/store queue credit uses its own dispatch count. One saturating event counter per structure records each cycle in which that structure was the reason the available batch could not be sent whole.

Top module: `credit_tracker`

## Requirements
- R1: After reset the three stored free counts and the in-flight count are zero, every event counter is zero and the stored empty flag is 1; with no instructions available, min_credit is 0, limit_src is 0, and stall, partial and grant_cnt are 0.
- R2: The reorder-buffer and issue-queue credits each equal the stored free count minus (in-flight count minus disp_cnt), computed as signed values, so they can be zero or negative.
- R3: A stored free count takes a new value at the clock edge only when its update-valid input is 1, and the new value first affects the credits in the following cycle. The empty flag is loaded from rob_empty_in only together with a reorder-buffer update.
- R4: The load/store-queue credit equals its stored free count minus (in-flight count minus lsq_disp_cnt); disp_cnt plays no part in it.
- R5: limit_src starts at 0 (reorder buffer). It becomes 1 (issue queue) only if that credit is strictly smaller, then 2 (load/store queue) only if that credit is strictly smaller than the minimum so far. min_credit is the credit of the chosen source, and limit_src never takes the value 3.
- R6: When avail_cnt is nonzero and min_credit is zero or negative, stall is 1 and grant_cnt is 0. With avail_cnt zero, stall is 0.
- R7: When min_credit is positive but smaller than a nonzero avail_cnt, partial is 1 and grant_cnt equals min_credit; otherwise, with no stall, grant_cnt equals avail_cnt and partial is 0.
- R8: In every cycle with avail_cnt nonzero and min_credit smaller than avail_cnt, the event counter of the limiting source increases by one. A counter saturates at all ones.
- R9: At each clock edge the in-flight count becomes its old value plus renamed_cnt minus disp_cnt. If that result would be negative it is held at zero instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_upd_vld | input | 1 | New reorder-buffer free count is valid |
| rob_free_in | input | CNT_W | Reorder-buffer free entries |
| rob_empty_in | input | 1 | Reorder buffer reported empty |
| iq_upd_vld | input | 1 | New issue-queue free count is valid |
| iq_free_in | input | CNT_W | Issue-queue free entries |
| lsq_upd_vld | input | 1 | New load/store-queue free count is valid |
| lsq_free_in | input | CNT_W | Load/store-queue free entries |
| renamed_cnt | input | DSP_W | Instructions renamed this cycle |
| disp_cnt | input | DSP_W | Instructions dispatched this cycle |
| lsq_disp_cnt | input | DSP_W | Instructions dispatched to the load/store queue this cycle |
| avail_cnt | input | DSP_W | Instructions waiting to be renamed |
| min_credit | output | CNT_W+2 | Smallest signed credit |
| limit_src | output | 2 | Limiting source: 0 reorder buffer, 1 issue queue, 2 load/store queue |
| stall | output | 1 | No instruction may be sent |
| partial | output | 1 | Batch clipped, block requested next cycle |
| grant_cnt | output | DSP_W | Instructions that may be sent |
| rob_empty | output | 1 | Stored empty flag |
| evt_rob | output | EVT_W | Reorder-buffer full events |
| evt_iq | output | EVT_W | Issue-queue full events |
| evt_lsq | output | EVT_W | Load/store-queue full events |

## Verification
Two functions can land in the same cycle: a producer loading a new free count while the credit is still being formed from the old one, and event counting at the moment two sources tie for the minimum. The vector table drives issue-queue updates in cycles where that queue limits or ties. It checks that the credit, source and event counter still follow the stored value from before the edge, and that a tie leaves the earlier source in place. Dispatch and load/store dispatch counts are set apart in the same cycles so that the two correction paths cannot be confused.

// File: rtl/credit_pkg.sv
package credit_pkg;
   typedef enum logic [1:0] {
      SRC_ROB = 2'd0,
      SRC_IQ  = 2'd1,
      SRC_LSQ = 2'd2
   } src_e;

   localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/cred_slot.sv
module cred_slot #(
   parameter int unsigned CNT_W = 6,
   parameter int unsigned DSP_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      upd_vld,
   input  logic [CNT_W-1:0]          free_in,
   input  logic [CNT_W-1:0]          infl,
   input  logic [DSP_W-1:0]          dsp,
   output logic signed [CNT_W+1:0]   credit
);
   localparam int unsigned CR_W = CNT_W + 2;

   logic [CNT_W-1:0]       free_q;
   logic signed [CR_W-1:0] free_s, infl_s, dsp_s;

   always_ff @(posedge clk) begin
      if (!rst_n)       free_q <= '0;
      else if (upd_vld) free_q <= free_in;
   end

   assign free_s = $signed(CR_W'(free_q));
   assign infl_s = $signed(CR_W'(infl));
   assign dsp_s  = $signed(CR_W'(dsp));
   assign credit = free_s - (infl_s - dsp_s);

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vld |=> (free_q == $past(free_in)));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_vld |=> $stable(free_q));
endmodule

// File: rtl/infl_track.sv
module infl_track #(
   parameter int unsigned CNT_W = 6,
   parameter int unsigned DSP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DSP_W-1:0] renamed,
   input  logic [DSP_W-1:0] disp,
   output logic [CNT_W-1:0] infl_q
);
   localparam int unsigned SW = CNT_W + 1;

   logic [SW-1:0] sum;
   logic          under;

   assign sum   = SW'(infl_q) + SW'(renamed);
   assign under = SW'(disp) > sum;

   always_ff @(posedge clk) begin
      if (!rst_n)     infl_q <= '0;
      else if (under) infl_q <= '0;
      else            infl_q <= CNT_W'(sum - SW'(disp));
   end

   assert_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (SW'(disp) > SW'(infl_q) + SW'(renamed)) |=> (infl_q == '0));
   assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (renamed == '0 && disp != '0 && infl_q != '0) |=> (infl_q < $past(infl_q)));
endmodule

// File: rtl/sat_ctr.sv
module sat_ctr #(
   parameter int unsigned EVT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [EVT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
   end

   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '1) |=> (cnt == '1));
   assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/credit_tracker.sv
module credit_tracker
   import credit_pkg::*;
#(
   parameter int unsigned CNT_W = 6,
   parameter int unsigned REN_W = 4,
   parameter int unsigned EVT_W = 3,
   localparam int unsigned DSP_W = $clog2(REN_W + 1),
   localparam int unsigned CR_W  = CNT_W + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rob_upd_vld,
   input  logic [CNT_W-1:0]       rob_free_in,
   input  logic                   rob_empty_in,
   input  logic                   iq_upd_vld,
   input  logic [CNT_W-1:0]       iq_free_in,
   input  logic                   lsq_upd_vld,
   input  logic [CNT_W-1:0]       lsq_free_in,
   input  logic [DSP_W-1:0]       renamed_cnt,
   input  logic [DSP_W-1:0]       disp_cnt,
   input  logic [DSP_W-1:0]       lsq_disp_cnt,
   input  logic [DSP_W-1:0]       avail_cnt,
   output logic signed [CR_W-1:0] min_credit,
   output logic [1:0]             limit_src,
   output logic                   stall,
   output logic                   partial,
   output logic [DSP_W-1:0]       grant_cnt,
   output logic                   rob_empty,
   output logic [EVT_W-1:0]       evt_rob,
   output logic [EVT_W-1:0]       evt_iq,
   output logic [EVT_W-1:0]       evt_lsq
);
   if (CNT_W < 2)      begin : g_bad_cnt  $error("CNT_W must be at least 2");  end
   if (REN_W < 1)      begin : g_bad_ren  $error("REN_W must be at least 1");  end
   if (EVT_W < 1)      begin : g_bad_evt  $error("EVT_W must be at least 1");  end
   if (DSP_W >= CR_W)  begin : g_bad_dsp  $error("REN_W too wide for CNT_W"); end

   logic                   vld_a  [NUM_SRC];
   logic [CNT_W-1:0]       fin_a  [NUM_SRC];
   logic [DSP_W-1:0]       dsp_a  [NUM_SRC];
   logic signed [CR_W-1:0] cr_a   [NUM_SRC];
   logic [EVT_W-1:0]       evt_a  [NUM_SRC];
   logic [CNT_W-1:0]       infl_q;
   logic signed [CR_W-1:0] avail_s;
   logic                   evt_fire;
   src_e                   sel;

   assign vld_a[SRC_ROB] = rob_upd_vld;
   assign vld_a[SRC_IQ]  = iq_upd_vld;
   assign vld_a[SRC_LSQ] = lsq_upd_vld;
   assign fin_a[SRC_ROB] = rob_free_in;
   assign fin_a[SRC_IQ]  = iq_free_in;
   assign fin_a[SRC_LSQ] = lsq_free_in;
   assign dsp_a[SRC_ROB] = disp_cnt;
   assign dsp_a[SRC_IQ]  = disp_cnt;
   assign dsp_a[SRC_LSQ] = lsq_disp_cnt;

   infl_track #(.CNT_W(CNT_W), .DSP_W(DSP_W)) u_infl (
      .clk(clk), .rst_n(rst_n), .renamed(renamed_cnt), .disp(disp_cnt), .infl_q(infl_q));

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      cred_slot #(.CNT_W(CNT_W), .DSP_W(DSP_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .upd_vld(vld_a[s]), .free_in(fin_a[s]),
         .infl(infl_q), .dsp(dsp_a[s]), .credit(cr_a[s]));

      sat_ctr #(.EVT_W(EVT_W)) u_evt (
         .clk(clk), .rst_n(rst_n), .inc(evt_fire && (sel == src_e'(s))), .cnt(evt_a[s]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           rob_empty <= 1'b1;
      else if (rob_upd_vld) rob_empty <= rob_empty_in;
   end

   always_comb begin
      sel        = SRC_ROB;
      min_credit = cr_a[SRC_ROB];
      if (cr_a[SRC_IQ] < min_credit) begin
         sel        = SRC_IQ;
         min_credit = cr_a[SRC_IQ];
      end
      if (cr_a[SRC_LSQ] < min_credit) begin
         sel        = SRC_LSQ;
         min_credit = cr_a[SRC_LSQ];
      end
   end

   assign avail_s   = $signed(CR_W'(avail_cnt));
   assign limit_src = sel;
   assign stall     = (avail_cnt != '0) && (min_credit <= 0);
   assign partial   = (avail_cnt != '0) && (min_credit > 0) && (min_credit < avail_s);
   assign evt_fire  = (avail_cnt != '0) && (min_credit < avail_s);
   assign grant_cnt = stall ? '0 : (partial ? DSP_W'(min_credit) : avail_cnt);

   assign evt_rob = evt_a[SRC_ROB];
   assign evt_iq  = evt_a[SRC_IQ];
   assign evt_lsq = evt_a[SRC_LSQ];

   assert_src_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      limit_src != 2'd3);
   assert_min_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (min_credit <= cr_a[SRC_ROB]) && (min_credit <= cr_a[SRC_IQ]) && (min_credit <= cr_a[SRC_LSQ]));
   assert_stall_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (grant_cnt == '0 && !partial));
   assert_partial_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      partial |-> (grant_cnt < avail_cnt && grant_cnt != '0));
   assert_empty_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rob_upd_vld |=> $stable(rob_empty));
endmodule

// File: tb/sim_credit_tracker.sv
module sim_credit_tracker;
   localparam int CNT_W = 6;
   localparam int DSP_W = 3;
   localparam int CR_W  = 8;

   typedef struct packed {
      logic             rv;  logic [CNT_W-1:0] rf;
      logic             iv;  logic [CNT_W-1:0] qf;
      logic             lv;  logic [CNT_W-1:0] lf;
      logic [DSP_W-1:0] ren; logic [DSP_W-1:0] dsp;
      logic [DSP_W-1:0] ldsp; logic [DSP_W-1:0] av;
      logic [CR_W-1:0]  ecr; logic [1:0] esrc;
      logic             est; logic ept; logic [DSP_W-1:0] egr;
   } vec_t;

   // rv rf iv qf lv lf ren dsp ldsp av | credit src stall partial grant
   localparam vec_t VECS [11] = '{
      '{1'b1,6'd10,1'b1,6'd8,1'b1,6'd6, 3'd0,3'd0,3'd0,3'd0, 8'd0,   2'd0,1'b0,1'b0,3'd0},
      '{1'b0,6'd0, 1'b0,6'd0,1'b0,6'd0, 3'd3,3'd0,3'd0,3'd4, 8'd6,   2'd2,1'b0,1'b0,3'd4},
      '{1'b0,6'd0, 1'b0,6'd0,1'b0,6'd0, 3'd0,3'd1,3'd0,3'd4, 8'd3,   2'd2,1'b0,1'b1,3'd3},
      '{1'b0,6'd0, 1'b0,6'd0,1'b0,6'd0, 3'd0,3'd0,3'd2,3'd2, 8'd6,   2'd1,1'b0,1'b0,3'd2},
      '{1'b0,6'd0, 1'b1,6'd2,1'b0,6'd0, 3'd0,3'd0,3'd0,3'd1, 8'd4,   2'd2,1'b0,1'b0,3'd1},
      '{1'b0,6'd0, 1'b0,6'd0,1'b0,6'd0, 3'd0,3'd0,3'd0,3'd3, 8'd0,   2'd1,1'b1,1'b0,3'd0},
      '{1'b1,6'd2, 1'b0,6'd0,1'b0,6'd0, 3'd0,3'd0,3'd0,3'd0, 8'd0,   2'd1,1'b0,1'b0,3'd0},
      '{1'b0,6'd0, 1'b1,6'd9,1'b0,6'd0, 3'd0,3'd0,3'd0,3'd2, 8'd0,   2'd0,1'b1,1'b0,3'd0},
      '{1'b0,6'd0, 1'b0,6'd0,1'b0,6'd0, 3'd0,3'd2,3'd2,3'd2, 8'd2,   2'd0,1'b0,1'b0,3'd2},
      '{1'b0,6'd0, 1'b0,6'd0,1'b0,6'd0, 3'd4,3'd0,3'd0,3'd4, 8'd2,   2'd0,1'b0,1'b1,3'd2},
      '{1'b0,6'd0, 1'b0,6'd0,1'b0,6'd0, 3'd0,3'd0,3'd0,3'd1, 8'hFE,  2'd0,1'b1,1'b0,3'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rob_upd_vld = 1'b0, iq_upd_vld = 1'b0, lsq_upd_vld = 1'b0, rob_empty_in = 1'b1;
   logic [CNT_W-1:0] rob_free_in = '0, iq_free_in = '0, lsq_free_in = '0;
   logic [DSP_W-1:0] renamed_cnt = '0, disp_cnt = '0, lsq_disp_cnt = '0, avail_cnt = '0;
   logic signed [CR_W-1:0] min_credit;
   logic [1:0] limit_src;
   logic stall, partial, rob_empty;
   logic [DSP_W-1:0] grant_cnt;
   logic [2:0] evt_rob, evt_iq, evt_lsq;
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   credit_tracker u0 (
      .clk(clk), .rst_n(rst_n),
      .rob_upd_vld(rob_upd_vld), .rob_free_in(rob_free_in), .rob_empty_in(rob_empty_in),
      .iq_upd_vld(iq_upd_vld), .iq_free_in(iq_free_in),
      .lsq_upd_vld(lsq_upd_vld), .lsq_free_in(lsq_free_in),
      .renamed_cnt(renamed_cnt), .disp_cnt(disp_cnt), .lsq_disp_cnt(lsq_disp_cnt),
      .avail_cnt(avail_cnt), .min_credit(min_credit), .limit_src(limit_src),
      .stall(stall), .partial(partial), .grant_cnt(grant_cnt), .rob_empty(rob_empty),
      .evt_rob(evt_rob), .evt_iq(evt_iq), .evt_lsq(evt_lsq));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic quiet();
      rob_upd_vld = 1'b0; iq_upd_vld = 1'b0; lsq_upd_vld = 1'b0;
      renamed_cnt = '0; disp_cnt = '0; lsq_disp_cnt = '0; avail_cnt = '0;
   endtask

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 credit", int'(min_credit), 0);
      chk("R1 src", int'(limit_src), 0);
      chk("R1 stall", int'(stall), 0);
      chk("R1 grant", int'(grant_cnt), 0);
      chk("R1 empty", int'(rob_empty), 1);
      chk("R1 events", int'(evt_rob) + int'(evt_iq) + int'(evt_lsq), 0);

      // table: R2 R3 R4 R5 R6 R7
      for (int i = 0; i < 11; i++) begin
         @(negedge clk);
         rob_upd_vld = VECS[i].rv; rob_free_in = VECS[i].rf;
         iq_upd_vld  = VECS[i].iv; iq_free_in  = VECS[i].qf;
         lsq_upd_vld = VECS[i].lv; lsq_free_in = VECS[i].lf;
         renamed_cnt = VECS[i].ren; disp_cnt = VECS[i].dsp;
         lsq_disp_cnt = VECS[i].ldsp; avail_cnt = VECS[i].av;
         #1;
         chk($sformatf("R2/R4 credit v%0d", i), int'(min_credit), int'($signed(VECS[i].ecr)));
         chk($sformatf("R5 src v%0d", i), int'(limit_src), int'(VECS[i].esrc));
         chk($sformatf("R6 stall v%0d", i), int'(stall), int'(VECS[i].est));
         chk($sformatf("R7 partial v%0d", i), int'(partial), int'(VECS[i].ept));
         chk($sformatf("R7 grant v%0d", i), int'(grant_cnt), int'(VECS[i].egr));
      end

      @(negedge clk);
      quiet();
      rob_empty_in = 1'b0;
      #1;
      // R8 event counts from the table
      chk("R8 evt rob", int'(evt_rob), 3);
      chk("R8 evt iq", int'(evt_iq), 1);
      chk("R8 evt lsq", int'(evt_lsq), 1);

      // R3 empty flag ignored without update
      @(negedge clk);
      chk("R3 empty held", int'(rob_empty), 1);
      rob_upd_vld = 1'b1; rob_free_in = 6'd2;
      @(negedge clk);
      rob_upd_vld = 1'b0;
      chk("R3 empty loaded", int'(rob_empty), 0);

      // R8 saturation, credit is -2 from ROB
      avail_cnt = 3'd1;
      #1;
      chk("R6 negative stall", int'(stall), 1);
      repeat (10) @(negedge clk);
      avail_cnt = '0;
      #1;
      chk("R8 evt rob saturated", int'(evt_rob), 7);
      chk("R8 evt iq untouched", int'(evt_iq), 1);

      // R9 clamp: in-flight 4, dispatch 7
      @(negedge clk);
      disp_cnt = 3'd7;
      @(negedge clk);
      disp_cnt = '0;
      #1;
      chk("R9 clamp credit", int'(min_credit), 2);
      chk("R9 clamp src", int'(limit_src), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule